// File: doc/BRIEF.md
# Cache Control Register and Index Selector

This block holds the control state for a split instruction cache and operand cache behind a single 32-bit register. Software writes the register to enable each cache, to choose how each cache builds its entry index from the effective address, to put the operand cache into a half-cache/half-RAM arrangement, to select a double-capacity mode, and to start a full invalidation of the instruction cache. A read returns the stored bits.

From an effective address, the block produces the instruction-cache and operand-cache entry indices. It also produces the cacheability qualifiers, which combine the enables with the page cacheable bit and the translation-enable flag. Invalidation runs as a sweep that clears one instruction-cache valid bit per clock. Writes that would put the operand mode bits into an illegal combination are filtered. Writes that would change the double-mode bit while either cache is enabled are also filtered.

Top module: `cache_ctl_top`

## Requirements
- R1: While rst_ni is low and on the cycle after release, rd_data_o is 0, inv_busy_o, vclr_o and cfg_err_o are 0, and both caches are disabled with the normal index mapping.
- R2: ic_idx_o is ea_i[12:5] when the instruction index-mode bit (register bit 2) is 0, and {ea_i[25], ea_i[11:5]} when it is 1. It is combinational from ea_i and the stored bit.
- R3: oc_idx_o is ea_i[13:5] when the operand index-mode bit (register bit 5) is 0, and {ea_i[25], ea_i[12:5]} when it is 1.
- R4: A write with bit 1 set raises inv_busy_o and vclr_o from the next cycle for 256 cycles, with vclr_idx_o stepping 0,1,...,255. A new such write restarts the sweep at 0. Bit 1 always reads back as 0.
- R5: ic_cacheable_o is 1 exactly when bit 0 (instruction enable) is 1, the sweep is idle, and either xlat_en_i is 0 or page_c_i is 1.
- R6: oc_ram_sel_o is 1 exactly when bit 4 (operand enable) and bit 6 (RAM mode) are both 1 and oc_idx_o[8] is 1. oc_cacheable_o is 1 exactly when the operand cache is enabled, oc_ram_sel_o is 0, and either xlat_en_i is 0 or page_c_i is 1.
- R7: The stored RAM-mode bit is 0 after any write whose bit 4 is 0.
- R8: A write with bits 5 and 6 both set leaves the stored bits 5 and 6 at their previous values, except that bit 6 is still cleared when bit 4 is written 0. The same write sets cfg_err_o, which stays 1 until reset.
- R9: Bit 8 (double mode) takes the written value only if bits 0 and 4 were both 0 before the write. Otherwise it is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data |
| ea_i | input | 32 | Effective address of the lookup |
| xlat_en_i | input | 1 | Address translation active |
| page_c_i | input | 1 | Page cacheable bit |
| ic_idx_o | output | 8 | Instruction-cache entry index |
| oc_idx_o | output | 9 | Operand-cache entry index |
| ic_cacheable_o | output | 1 | Instruction access may use the cache |
| oc_cacheable_o | output | 1 | Operand access may use the cache |
| oc_ram_sel_o | output | 1 | Operand access targets the RAM half |
| dbl_mode_o | output | 1 | Double-mode bit |
| vclr_o | output | 1 | Clear the valid bit at vclr_idx_o this cycle |
| vclr_idx_o | output | 8 | Index of the entry being cleared |
| inv_busy_o | output | 1 | Invalidation sweep in progress |
| cfg_err_o | output | 1 | Sticky illegal-mode write flag |

## Verification
The indices and qualifiers are combinational from ea_i and the stored bits, so the bench checks them in the same cycle that ea_i is driven. A register write takes effect at the clock edge that samples it, so rd_data_o and the mode-dependent outputs show the new value from the following cycle. The sweep outputs start one cycle after the invalidate write, and inv_busy_o falls 256 edges later. The bench drives its inputs at the falling edge and compares every output one nanosecond later against a model that advances at each rising edge. Each result is therefore checked in exactly the cycle it is due.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;
  localparam int BIT_IC_EN  = 0;
  localparam int BIT_IC_INV = 1;
  localparam int BIT_IC_HI  = 2;
  localparam int BIT_OC_EN  = 4;
  localparam int BIT_OC_HI  = 5;
  localparam int BIT_OC_RAM = 6;
  localparam int BIT_DBL    = 8;

  typedef struct packed {
    logic dbl;
    logic oc_ram;
    logic oc_hi;
    logic oc_en;
    logic ic_hi;
    logic ic_en;
  } ctl_t;
endpackage

// File: rtl/cache_ctl_reg.sv
module cache_ctl_reg
  import cache_ctl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output ctl_t        ctl_o,
  output logic        inv_start_o,
  output logic        err_o,
  output logic [31:0] rd_data_o
);
  ctl_t ctl_q, ctl_d;
  logic err_q;
  logic clash;

  assign clash = wr_data_i[BIT_OC_HI] & wr_data_i[BIT_OC_RAM];

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en_i) begin
      ctl_d.ic_en  = wr_data_i[BIT_IC_EN];
      ctl_d.ic_hi  = wr_data_i[BIT_IC_HI];
      ctl_d.oc_en  = wr_data_i[BIT_OC_EN];
      ctl_d.oc_hi  = clash ? ctl_q.oc_hi : wr_data_i[BIT_OC_HI];
      // RAM mode only survives while the operand cache is on
      ctl_d.oc_ram = (clash ? ctl_q.oc_ram : wr_data_i[BIT_OC_RAM]) & wr_data_i[BIT_OC_EN];
      if (!(ctl_q.ic_en || ctl_q.oc_en)) ctl_d.dbl = wr_data_i[BIT_DBL];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      err_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      if (wr_en_i && clash) err_q <= 1'b1;
    end
  end

  assign ctl_o       = ctl_q;
  assign err_o       = err_q;
  assign inv_start_o = wr_en_i & wr_data_i[BIT_IC_INV];

  always_comb begin
    rd_data_o             = '0;
    rd_data_o[BIT_IC_EN]  = ctl_q.ic_en;
    rd_data_o[BIT_IC_HI]  = ctl_q.ic_hi;
    rd_data_o[BIT_OC_EN]  = ctl_q.oc_en;
    rd_data_o[BIT_OC_HI]  = ctl_q.oc_hi;
    rd_data_o[BIT_OC_RAM] = ctl_q.oc_ram;
    rd_data_o[BIT_DBL]    = ctl_q.dbl;
  end

  assert_oc_modes_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_q.oc_hi && ctl_q.oc_ram));
  assert_ram_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.oc_ram |-> ctl_q.oc_en);
  assert_dbl_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.ic_en || ctl_q.oc_en) |=> $stable(ctl_q.dbl));
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: rtl/cache_idx_sel.sv
module cache_idx_sel #(
  parameter int ADDR_W   = 32,
  parameter int LINE_LSB = 5,
  parameter int IDX_W    = 8,
  parameter int HI_BIT   = 25
) (
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              hi_mode_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int TOP = LINE_LSB + IDX_W - 1;

  logic [IDX_W-1:0] norm_idx, hi_idx;

  assign norm_idx = ea_i[TOP:LINE_LSB];
  assign hi_idx   = {ea_i[HI_BIT], ea_i[TOP-1:LINE_LSB]};
  assign idx_o    = hi_mode_i ? hi_idx : norm_idx;
endmodule

// File: rtl/ic_inv_sweep.sv
module ic_inv_sweep #(
  parameter int N_ENT = 256
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  output logic                     busy_o,
  output logic                     clr_o,
  output logic [$clog2(N_ENT)-1:0] clr_idx_o
);
  localparam int CW = $clog2(N_ENT);
  localparam logic [CW-1:0] LAST = CW'(N_ENT - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign clr_o     = busy_q;
  assign clr_idx_o = cnt_q;

  assert_sweep_steps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  assert_sweep_ends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && cnt_q == LAST) |=> !busy_q);
  assert_start_restarts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && cnt_q == '0));
endmodule

// File: rtl/cache_ctl_top.sv
module cache_ctl_top
  import cache_ctl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_LSB = 5,
  parameter int IC_IDX_W = 8,
  parameter int OC_IDX_W = 9,
  parameter int HI_BIT   = 25
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [31:0]         wr_data_i,
  output logic [31:0]         rd_data_o,
  input  logic [ADDR_W-1:0]   ea_i,
  input  logic                xlat_en_i,
  input  logic                page_c_i,
  output logic [IC_IDX_W-1:0] ic_idx_o,
  output logic [OC_IDX_W-1:0] oc_idx_o,
  output logic                ic_cacheable_o,
  output logic                oc_cacheable_o,
  output logic                oc_ram_sel_o,
  output logic                dbl_mode_o,
  output logic                vclr_o,
  output logic [IC_IDX_W-1:0] vclr_idx_o,
  output logic                inv_busy_o,
  output logic                cfg_err_o
);
  localparam int IC_ENT = 1 << IC_IDX_W;

  ctl_t ctl;
  logic inv_start, page_ok;

  cache_ctl_reg u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .ctl_o(ctl), .inv_start_o(inv_start), .err_o(cfg_err_o), .rd_data_o
  );

  cache_idx_sel #(.ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB), .IDX_W(IC_IDX_W), .HI_BIT(HI_BIT)) u_ic_idx (
    .ea_i, .hi_mode_i(ctl.ic_hi), .idx_o(ic_idx_o)
  );

  cache_idx_sel #(.ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB), .IDX_W(OC_IDX_W), .HI_BIT(HI_BIT)) u_oc_idx (
    .ea_i, .hi_mode_i(ctl.oc_hi), .idx_o(oc_idx_o)
  );

  ic_inv_sweep #(.N_ENT(IC_ENT)) u_sweep (
    .clk_i, .rst_ni, .start_i(inv_start),
    .busy_o(inv_busy_o), .clr_o(vclr_o), .clr_idx_o(vclr_idx_o)
  );

  assign page_ok        = !xlat_en_i || page_c_i;
  assign ic_cacheable_o = ctl.ic_en && page_ok && !inv_busy_o;
  // index MSB picks the RAM half
  assign oc_ram_sel_o   = ctl.oc_en && ctl.oc_ram && oc_idx_o[OC_IDX_W-1];
  assign oc_cacheable_o = ctl.oc_en && page_ok && !oc_ram_sel_o;
  assign dbl_mode_o     = ctl.dbl;

  assert_no_hit_while_sweep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_busy_o |-> !ic_cacheable_o);
  assert_ram_half_uncached_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_ram_sel_o |-> !oc_cacheable_o);
  assert_sweep_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_busy_o |-> vclr_o);
endmodule

// File: tb/cache_ctl_top_tb.sv
`timescale 1ns/1ps
module cache_ctl_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [31:0] wr_data_i;
  logic [31:0] rd_data_o;
  logic [31:0] ea_i;
  logic        xlat_en_i, page_c_i;
  logic [7:0]  ic_idx_o;
  logic [8:0]  oc_idx_o;
  logic        ic_cacheable_o, oc_cacheable_o, oc_ram_sel_o, dbl_mode_o;
  logic        vclr_o, inv_busy_o, cfg_err_o;
  logic [7:0]  vclr_idx_o;

  int errs = 0;
  int checks = 0;

  // reference model state
  bit m_ic_en, m_ic_hi, m_oc_en, m_oc_hi, m_oc_ram, m_dbl, m_err, m_busy;
  int m_cnt;

  always #2.5 clk_i = ~clk_i;

  cache_ctl_top dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o, .ea_i, .xlat_en_i, .page_c_i,
    .ic_idx_o, .oc_idx_o, .ic_cacheable_o, .oc_cacheable_o, .oc_ram_sel_o, .dbl_mode_o,
    .vclr_o, .vclr_idx_o, .inv_busy_o, .cfg_err_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] e_rd;
    bit pg, rsel;
    logic [7:0] e_ic;
    logic [8:0] e_oc;
    e_rd = 0;
    e_rd[0] = m_ic_en; e_rd[2] = m_ic_hi; e_rd[4] = m_oc_en;
    e_rd[5] = m_oc_hi; e_rd[6] = m_oc_ram; e_rd[8] = m_dbl;
    pg   = !xlat_en_i || page_c_i;
    e_ic = m_ic_hi ? {ea_i[25], ea_i[11:5]} : ea_i[12:5];
    e_oc = m_oc_hi ? {ea_i[25], ea_i[12:5]} : ea_i[13:5];
    rsel = m_oc_en && m_oc_ram && e_oc[8];
    chk("R7/R8/R9", "rd_data", rd_data_o, e_rd);
    chk("R9", "dbl_mode", 32'(dbl_mode_o), 32'(m_dbl));
    chk("R2", "ic_idx", 32'(ic_idx_o), 32'(e_ic));
    chk("R3", "oc_idx", 32'(oc_idx_o), 32'(e_oc));
    chk("R4", "busy", 32'(inv_busy_o), 32'(m_busy));
    chk("R4", "vclr", 32'(vclr_o), 32'(m_busy));
    if (m_busy) chk("R4", "vclr_idx", 32'(vclr_idx_o), 32'(m_cnt));
    chk("R5", "ic_cacheable", 32'(ic_cacheable_o), 32'(m_ic_en && pg && !m_busy));
    chk("R6", "oc_ram_sel", 32'(oc_ram_sel_o), 32'(rsel));
    chk("R6", "oc_cacheable", 32'(oc_cacheable_o), 32'(m_oc_en && pg && !rsel));
    chk("R8", "cfg_err", 32'(cfg_err_o), 32'(m_err));
  endtask

  task automatic model_step(input bit we, input logic [31:0] wd);
    bit clash;
    if (we) begin
      clash = wd[5] && wd[6];
      if (clash) m_err = 1;
      if (!(m_ic_en || m_oc_en)) m_dbl = wd[8];
      m_ic_en  = wd[0];
      m_ic_hi  = wd[2];
      m_oc_en  = wd[4];
      if (!clash) begin m_oc_hi = wd[5]; m_oc_ram = wd[6]; end
      if (!wd[4]) m_oc_ram = 0;
    end
    if (we && wd[1]) begin
      m_busy = 1; m_cnt = 0;
    end else if (m_busy) begin
      if (m_cnt == 255) m_busy = 0;
      else m_cnt++;
    end
  endtask

  task automatic cycle(input bit we, input logic [31:0] wd);
    @(negedge clk_i);
    wr_en_i   = we;
    wr_data_i = wd;
    ea_i      = $urandom;
    xlat_en_i = 1'($urandom);
    page_c_i  = 1'($urandom);
    #1;
    compare_all();
    @(posedge clk_i);
    model_step(we, wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errs++;
    $display("FAIL R1 watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; wr_en_i = 0; wr_data_i = 0; ea_i = 32'hffff_ffff; xlat_en_i = 0; page_c_i = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk("R1", "rd_data in reset", rd_data_o, 32'h0);
    chk("R1", "busy in reset", 32'(inv_busy_o), 32'h0);
    chk("R1", "vclr in reset", 32'(vclr_o), 32'h0);
    chk("R1", "err in reset", 32'(cfg_err_o), 32'h0);
    chk("R1", "ic_idx normal in reset", 32'(ic_idx_o), 32'hff);
    rst_ni = 1'b1;
    idle(4);
    // R2 index modes
    cycle(1, 32'h0000_0001); idle(20);
    cycle(1, 32'h0000_0005); idle(20);
    // R4 invalidate sweep, with a restart midway
    cycle(1, 32'h0000_0007); idle(100);
    cycle(1, 32'h0000_0003); idle(262);
    // R3 / R6 operand modes
    cycle(1, 32'h0000_0030); idle(20);
    cycle(1, 32'h0000_0050); idle(40);
    // R8 clash write rejected
    cycle(1, 32'h0000_0071); idle(10);
    // R7 RAM bit dropped without enable
    cycle(1, 32'h0000_0040); idle(5);
    // R9 double mode locked, then unlocked
    cycle(1, 32'h0000_0011); cycle(1, 32'h0000_0111); idle(3);
    cycle(1, 32'h0000_0000); cycle(1, 32'h0000_0100); idle(3);
    cycle(1, 32'h0000_0001); cycle(1, 32'h0000_0000); idle(3);
    // random writes
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 8) != 0) d[1] = 1'b0;
      cycle(($urandom % 4) == 0, d);
    end
    idle(270);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule